// File: doc/BRIEF.md
# Second-Block Selector Prediction Table

This block lets a fetch unit predict the line after next in the same cycle as the next line. The full prediction path uses instruction type and pattern history to produce a next-line multiplexer selector. Its result is not ready in time to steer the second block. This table instead holds the selector that an earlier full prediction produced, plus a short history-advance code. Each entry stores a selector, the number of not-taken conditionals the block contributes to global history, and a bit that marks the exit as taken or fall-through.

A lookup is made in the prediction stage. The table index is the global history XOR the block address, which is the same value the pattern table uses for the first block. The low bits of the start slot are placed above it, so the table is split into 2^BANK_BITS sub-tables. In the next cycle the full logic delivers the correct selector and history code. The table compares them with what it handed out. On any difference it raises a misselect, puts the correct selector on the refetch output and writes the correct entry back. A separate recovery port lets branch resolution install a precomputed replacement entry. The recovery port and the verify path share one write port, and a recovery write wins.

Top module: `blk_sel_table`

## Requirements
- R1: After reset every entry reads as selector FT_SEL, not-taken count 0 and exit bit 0, where exit bit 0 means fall-through and 1 means taken.
- R2: The entry addressed is {start_slot[BANK_BITS-1:0], hist XOR addr}. Two lookups with equal XOR and equal low slot bits reach the same entry. Entries differing only in the low slot bits are independent. Slot bits above BANK_BITS are ignored.
- R3: The prediction outputs show the addressed entry's selector, count and exit bit in the same cycle as the lookup.
- R4: `misselect` is high in the cycle after a lookup with `rd_en` high, exactly when any of selector, count or exit bit differs from the verify inputs.
- R5: On a misselect with no recovery write, the looked-up entry holds the verify values from the next cycle on, and `fix_sel` equals `vf_sel` while `misselect` is high.
- R6: A recovery write stores its selector, count and exit bit at the addressed entry at the clock edge.
- R7: When a recovery write and a misselect occur in the same cycle, the recovery write is applied. The verify correction is dropped and its entry keeps its old value, unless the recovery write hit that same entry.
- R8: A lookup of the entry being written in the same cycle returns the new data, whether the write comes from recovery or from a verify correction.
- R9: In a cycle not preceded by a lookup with `rd_en` high, the verify inputs are ignored: `misselect` stays low and no entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Lookup is a real prediction to verify next cycle |
| rd_hist | input | HIST_W | Global history for lookup |
| rd_addr | input | HIST_W | Block address bits for lookup |
| rd_slot | input | SLOT_W | Starting slot within the line |
| pr_sel | output | SEL_W | Predicted next-line selector |
| pr_cnt | output | CNT_W | Predicted not-taken conditional count |
| pr_taken | output | 1 | Predicted exit kind (1 taken) |
| vf_sel | input | SEL_W | Correct selector from full logic |
| vf_cnt | input | CNT_W | Correct not-taken count |
| vf_taken | input | 1 | Correct exit kind |
| misselect | output | 1 | Stored prediction differed from verify values |
| fix_sel | output | SEL_W | Replacement selector for refetch |
| rc_en | input | 1 | Recovery write enable |
| rc_hist | input | HIST_W | History for recovery index |
| rc_addr | input | HIST_W | Block address for recovery index |
| rc_slot | input | SLOT_W | Start slot for recovery index |
| rc_sel | input | SEL_W | Replacement selector |
| rc_cnt | input | CNT_W | Replacement not-taken count |
| rc_taken | input | 1 | Replacement exit kind |

## Verification
The bench builds the table with a 3-bit history, a 2-bit slot and one bank bit, which gives 16 entries. It also sets a non-zero fall-through selector so that the reset value is distinguishable from zero. At this size every entry can be reset-checked, written, verified with each kind of mismatch and read back. Each entry is reached through several hist/addr pairs with the same XOR and through varying upper slot bits. The write-port collisions and bypass cases can also be placed at chosen entries.

// File: rtl/blk_sel_table.sv
module blk_sel_table #(
  parameter int HIST_W    = 10,
  parameter int SLOT_W    = 3,
  parameter int BANK_BITS = 0,
  parameter int SEL_W     = 4,
  parameter int CNT_W     = 4,
  parameter int FT_SEL    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [HIST_W-1:0] rd_hist,
  input  logic [HIST_W-1:0] rd_addr,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [SEL_W-1:0]  pr_sel,
  output logic [CNT_W-1:0]  pr_cnt,
  output logic              pr_taken,
  input  logic [SEL_W-1:0]  vf_sel,
  input  logic [CNT_W-1:0]  vf_cnt,
  input  logic              vf_taken,
  output logic              misselect,
  output logic [SEL_W-1:0]  fix_sel,
  input  logic              rc_en,
  input  logic [HIST_W-1:0] rc_hist,
  input  logic [HIST_W-1:0] rc_addr,
  input  logic [SLOT_W-1:0] rc_slot,
  input  logic [SEL_W-1:0]  rc_sel,
  input  logic [CNT_W-1:0]  rc_cnt,
  input  logic              rc_taken
);
  localparam int ENT_W = SEL_W + CNT_W + 1;
  localparam int IDX_W = HIST_W + BANK_BITS;
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [ENT_W-1:0] FT_ENT = {SEL_W'(FT_SEL), {CNT_W{1'b0}}, 1'b0};

  function automatic logic [IDX_W-1:0] mk_idx(input logic [HIST_W-1:0] h,
                                              input logic [HIST_W-1:0] a,
                                              input logic [SLOT_W-1:0] s);
    return IDX_W'({s, h ^ a});
  endfunction

  logic [ENT_W-1:0] mem [DEPTH];
  logic             p_valid;
  logic [IDX_W-1:0] p_idx;
  logic [ENT_W-1:0] p_ent;

  wire [IDX_W-1:0] rd_idx  = mk_idx(rd_hist, rd_addr, rd_slot);
  wire [IDX_W-1:0] rc_idx  = mk_idx(rc_hist, rc_addr, rc_slot);
  wire [ENT_W-1:0] act     = {vf_sel, vf_cnt, vf_taken};
  wire [ENT_W-1:0] rc_ent  = {rc_sel, rc_cnt, rc_taken};

  assign misselect = p_valid && (p_ent != act);
  assign fix_sel   = vf_sel;

  wire             wr_en   = rc_en | misselect;
  wire [IDX_W-1:0] wr_idx  = rc_en ? rc_idx : p_idx;
  wire [ENT_W-1:0] wr_data = rc_en ? rc_ent : act;

  wire [ENT_W-1:0] rd_ent = (wr_en && wr_idx == rd_idx) ? wr_data : mem[rd_idx];
  assign {pr_sel, pr_cnt, pr_taken} = rd_ent;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= FT_ENT;
      p_valid <= 1'b0;
      p_idx   <= '0;
      p_ent   <= FT_ENT;
    end else begin
      if (wr_en) mem[wr_idx] <= wr_data;
      p_valid <= rd_en;
      p_idx   <= rd_idx;
      p_ent   <= rd_ent;
    end
  end

  AST_MISSEL_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    misselect |-> $past(rd_en)); // R4

  AST_RECOVERY_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    rc_en |=> mem[$past(rc_idx)] == $past(rc_ent)); // R6

  AST_VERIFY_FIXES: assert property (@(posedge clk) disable iff (!rst_n)
    (misselect && !rc_en) |=> mem[$past(p_idx)] == $past(act)); // R5

  AST_BLOCKED_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (misselect && rc_en && rc_idx != p_idx) |=> mem[$past(p_idx)] == $past(mem[p_idx])); // R7
endmodule

// File: tb/sim_blk_sel_table.sv
module sim_blk_sel_table;
  logic clk = 0, rst_n = 0;
  logic rd_en = 0, rc_en = 0, vf_taken = 0, rc_taken = 0, pr_taken, misselect;
  logic [2:0] rd_hist = 0, rd_addr = 0, rc_hist = 0, rc_addr = 0;
  logic [1:0] rd_slot = 0, rc_slot = 0;
  logic [3:0] pr_sel, pr_cnt, vf_sel = 0, vf_cnt = 0, fix_sel, rc_sel = 0, rc_cnt = 0;
  logic [8:0] exp_m [16];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  blk_sel_table #(.HIST_W(3), .SLOT_W(2), .BANK_BITS(1), .SEL_W(4), .CNT_W(4), .FT_SEL(5)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_hist(rd_hist), .rd_addr(rd_addr),
    .rd_slot(rd_slot), .pr_sel(pr_sel), .pr_cnt(pr_cnt), .pr_taken(pr_taken),
    .vf_sel(vf_sel), .vf_cnt(vf_cnt), .vf_taken(vf_taken), .misselect(misselect),
    .fix_sel(fix_sel), .rc_en(rc_en), .rc_hist(rc_hist), .rc_addr(rc_addr),
    .rc_slot(rc_slot), .rc_sel(rc_sel), .rc_cnt(rc_cnt), .rc_taken(rc_taken));

  task automatic cmp(string tag, logic [8:0] got, logic [8:0] want);
    n_run++;
    if (got !== want) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, want);
    end
  endtask

  task automatic set_rd(int i, int h);
    rd_hist = 3'(h);
    rd_addr = 3'(h) ^ 3'(i);
    rd_slot = {1'(h), 1'(i >> 3)};
  endtask

  task automatic set_rc(int i, int h, logic [8:0] d);
    rc_hist = 3'(h);
    rc_addr = 3'(h) ^ 3'(i);
    rc_slot = {1'(h >> 1), 1'(i >> 3)};
    {rc_sel, rc_cnt, rc_taken} = d;
  endtask

  task automatic next();
    @(negedge clk);
  endtask

  function automatic logic [8:0] pr();
    return {pr_sel, pr_cnt, pr_taken};
  endfunction

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [8:0] act, d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 16; i++) begin
      exp_m[i] = 9'h0A0;
      set_rd(i, i * 5); #1 cmp("R1 reset entry", pr(), exp_m[i]);
    end
    cmp("R4 no misselect after reset", {8'd0, misselect}, 9'd0);
    for (int i = 0; i < 16; i++) begin
      d = 9'((i * 37 + 11) % 512);
      rc_en = 1; set_rc(i, i ^ 3, d); exp_m[i] = d;
      next();
    end
    rc_en = 0;
    for (int i = 0; i < 16; i++) begin
      set_rd(i, i + 6); #1 cmp("R6/R2 recovery readback", pr(), exp_m[i]);
    end
    for (int i = 0; i < 16; i++) begin
      next(); set_rd(i, i * 3); rd_en = 1;
      #1 cmp("R3 lookup", pr(), exp_m[i]);
      next(); rd_en = 0;
      case (i % 4)
        0: act = exp_m[i];
        1: act = exp_m[i] ^ 9'h100;
        2: act = exp_m[i] ^ 9'h002;
        default: act = exp_m[i] ^ 9'h001;
      endcase
      {vf_sel, vf_cnt, vf_taken} = act;
      #1 cmp("R4 misselect", {8'd0, misselect}, {8'd0, (i % 4) != 0});
      if (i % 4 != 0) cmp("R5 fix_sel", {5'd0, fix_sel}, {5'd0, act[8:5]});
      exp_m[i] = act;
      next(); set_rd(i, 7);
      #1 cmp("R5 corrected entry", pr(), exp_m[i]);
    end
    next(); set_rd(2, 1); rd_en = 1;
    next(); rd_en = 0; {vf_sel, vf_cnt, vf_taken} = exp_m[2] ^ 9'h100;
    rc_en = 1; set_rc(9, 4, 9'h155);
    #1 cmp("R7 misselect with recovery", {8'd0, misselect}, 9'd1);
    exp_m[9] = 9'h155;
    next(); rc_en = 0; set_rd(2, 0);
    #1 cmp("R7 verify write dropped", pr(), exp_m[2]);
    set_rd(9, 2); #1 cmp("R7 recovery applied", pr(), exp_m[9]);
    next(); set_rd(4, 6); rd_en = 1;
    next(); rd_en = 0; {vf_sel, vf_cnt, vf_taken} = exp_m[4] ^ 9'h002;
    rc_en = 1; set_rc(4, 5, 9'h0E3); exp_m[4] = 9'h0E3;
    next(); rc_en = 0; set_rd(4, 3);
    #1 cmp("R7 same entry recovery wins", pr(), exp_m[4]);
    next(); rc_en = 1; set_rc(11, 2, 9'h1C6); set_rd(11, 6);
    #1 cmp("R8 recovery bypass", pr(), 9'h1C6);
    exp_m[11] = 9'h1C6;
    next(); rc_en = 0; set_rd(6, 1); rd_en = 1;
    next(); act = exp_m[6] ^ 9'h001; {vf_sel, vf_cnt, vf_taken} = act; set_rd(6, 4);
    #1 cmp("R8 verify bypass", pr(), act);
    exp_m[6] = act;
    next(); rd_en = 0;
    #1 cmp("R8 bypassed read verifies clean", {8'd0, misselect}, 9'd0);
    next(); {vf_sel, vf_cnt, vf_taken} = ~exp_m[0];
    #1 cmp("R9 no lookup no misselect", {8'd0, misselect}, 9'd0);
    next(); {vf_sel, vf_cnt, vf_taken} = 9'h1FF;
    #1 cmp("R9 no lookup no misselect", {8'd0, misselect}, 9'd0);
    for (int i = 0; i < 16; i++) begin
      next(); set_rd(i, 2 * i + 1);
      #1 cmp("R9/R2 final contents", pr(), exp_m[i]);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule